// File: doc/BRIEF.md
# ECC Error Capture Registers

This block sits beside a memory ECC checker and keeps a record of the most important error seen since software last cleared it. Each cycle the checker may flag a correctable or an uncorrectable error. With the flag it gives the failing address, an 8-bit syndrome and the channel number. The block sets a sticky status bit for each kind of error. It captures the details of the error under a fixed priority: an uncorrectable error takes precedence over a correctable one. The block can also drive a level system-error request, which an enable mask gates.

Software polls the block through a plain register port. Writes take effect in one cycle and reads are combinational. Software clears status by writing ones to the status bits. An uncorrectable error can arrive while a correctable error is pending. It then replaces the captured details, so software that reads the status and then the details may see them change between the two reads.

Top module: `ecc_err_log`

Register offsets on `reg_addr`: 0 status, 1 command, 2 error address, 3 syndrome, 4 channel. Other offsets read as zero.

## Requirements
- R1: After reset every register reads zero and `sys_err` is low.
- R2: A correctable event (`ce_evt`) sets status bit 0. If no error of either kind is pending and no uncorrectable event arrives in the same cycle, it also captures the address, syndrome and channel. All of these are readable in the cycle after the event.
- R3: An uncorrectable event (`ue_evt`) sets status bit 7. If no uncorrectable error is pending, it captures the address, syndrome and channel.
- R4: An uncorrectable event that arrives while a correctable error is pending overwrites the captured details. Both status bits then read set (status value 0x0081).
- R5: A correctable event that arrives while an uncorrectable error is pending changes no captured detail.
- R6: A second correctable event while one is pending keeps the first event's details.
- R7: Writing a 1 to status bit 0 or bit 7 clears that bit. Writing a 0 to either bit has no effect. Status bits other than 0 and 7 always read zero.
- R8: An event and a clear write for the same status bit in the same cycle leave the bit set.
- R9: Command register bit 7 enables the system error for correctable errors and bit 8 enables it for uncorrectable errors. Other command bits read zero. `sys_err` is high exactly when some pending status bit has its enable set.
- R10: The error address register returns event address bits 31:12 in bits 31:12 and zero in bits 11:0. The channel register returns the channel in bit 0 and zero in bits 7:1 and above.
- R11: A correctable and an uncorrectable event in the same cycle set both status bits and capture the uncorrectable event's details.
- R12: A second uncorrectable event while one is pending keeps the first uncorrectable event's details.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error event, one cycle per event |
| ue_evt | input | 1 | Uncorrectable error event, one cycle per event |
| evt_addr | input | 32 | Failing address of the event |
| evt_syn | input | 8 | ECC syndrome of the event |
| evt_chan | input | 1 | Channel of the event |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| sys_err | output | 1 | System-error request level |

## Verification
The bench drives the priority corners one at a time. These are an uncorrectable event over a pending correctable one, a correctable event against a pending uncorrectable one, repeated events of the same kind, and both kinds in the same cycle. A design with the priority wrong would show the later correctable syndrome, or would lose the uncorrectable details. The bench also places a clear write in the same cycle as an event. A design that lets the clear win would drop an error with no trace. The bench checks that zero bits in a clear write do nothing and that unused status and command bits read zero. It steps through the enable mask with one error kind pending at a time, so that a swapped or ungated enable shows on `sys_err`.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CMD    = 3'd1,
    RA_ADDR   = 3'd2,
    RA_SYN    = 3'd3,
    RA_CHAN   = 3'd4
  } reg_sel_e;

  // Bit positions that software decodes
  localparam int ST_CE_BIT = 0;
  localparam int ST_UE_BIT = 7;
  localparam int EN_CE_BIT = 7;
  localparam int EN_UE_BIT = 8;

  // Index of each error kind in the per-kind vectors
  localparam int K_CE   = 0;
  localparam int K_UE   = 1;
  localparam int NKINDS = 2;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NKINDS-1:0] evt,
  input  logic [NKINDS-1:0] clr,
  input  logic              cmd_we,
  input  logic [NKINDS-1:0] cmd_d,
  output logic [NKINDS-1:0] pend,
  output logic [NKINDS-1:0] en
);
  logic [NKINDS-1:0] pend_nxt;

  // One sticky bit per error kind; the event wins over a clear
  for (genvar k = 0; k < NKINDS; k++) begin : g_kind
    always_comb begin
      pend_nxt[k] = pend[k];
      if (clr[k]) pend_nxt[k] = 1'b0;
      if (evt[k]) pend_nxt[k] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[k] <= 1'b0;
      else        pend[k] <= pend_nxt[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (cmd_we) en <= cmd_d;
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_evt,
  input  logic             ue_evt,
  input  logic             ce_pend,
  input  logic             ue_pend,
  input  logic [BLK_W-1:0] evt_blk,
  input  logic [SYN_W-1:0] evt_syn,
  input  logic             evt_chan,
  output logic [BLK_W-1:0] det_blk,
  output logic [SYN_W-1:0] det_syn,
  output logic             det_chan
);
  logic cap_ue, cap_ce, cap_en;

  // Uncorrectable replaces anything but an earlier uncorrectable;
  // correctable only fills an empty record.
  always_comb begin
    cap_ue = ue_evt && !ue_pend;
    cap_ce = ce_evt && !ue_evt && !ce_pend && !ue_pend;
    cap_en = cap_ue || cap_ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_blk  <= '0;
      det_syn  <= '0;
      det_chan <= 1'b0;
    end else if (cap_en) begin
      det_blk  <= evt_blk;
      det_syn  <= evt_syn;
      det_chan <= evt_chan;
    end
  end
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  localparam int BLK_W  = DATA_W - BLK_LSB
) (
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NKINDS-1:0] pend,
  input  logic [NKINDS-1:0] en,
  input  logic [BLK_W-1:0]  det_blk,
  input  logic [SYN_W-1:0]  det_syn,
  input  logic              det_chan,
  output logic [NKINDS-1:0] clr,
  output logic              cmd_we,
  output logic [NKINDS-1:0] cmd_d,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e sel;
  logic     wdata_unused;

  assign sel          = reg_sel_e'(reg_addr);
  assign wdata_unused = ^reg_wdata;

  always_comb begin
    clr          = '0;
    cmd_we       = 1'b0;
    cmd_d[K_CE]  = reg_wdata[EN_CE_BIT];
    cmd_d[K_UE]  = reg_wdata[EN_UE_BIT];
    if (reg_wr) begin
      if (sel == RA_STATUS) begin
        clr[K_CE] = reg_wdata[ST_CE_BIT];
        clr[K_UE] = reg_wdata[ST_UE_BIT];
      end
      if (sel == RA_CMD) cmd_we = 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_STATUS: begin
        reg_rdata[ST_CE_BIT] = pend[K_CE];
        reg_rdata[ST_UE_BIT] = pend[K_UE];
      end
      RA_CMD: begin
        reg_rdata[EN_CE_BIT] = en[K_CE];
        reg_rdata[EN_UE_BIT] = en[K_UE];
      end
      RA_ADDR: reg_rdata[DATA_W-1:BLK_LSB] = det_blk;
      RA_SYN:  reg_rdata[SYN_W-1:0]        = det_syn;
      RA_CHAN: reg_rdata[0]                = det_chan;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              sys_err
);
  logic [NKINDS-1:0] evt, clr, pend, en, cmd_d;
  logic              cmd_we;
  logic              ce_st, ue_st;
  logic [BLK_W-1:0]  det_blk;
  logic [SYN_W-1:0]  det_syn;
  logic              det_chan;
  logic              addr_lo_unused;

  assign evt[K_CE]      = ce_evt;
  assign evt[K_UE]      = ue_evt;
  assign ce_st          = pend[K_CE];
  assign ue_st          = pend[K_UE];
  assign addr_lo_unused = ^evt_addr[BLK_LSB-1:0];

  ecc_log_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (clr),
    .cmd_we (cmd_we),
    .cmd_d  (cmd_d),
    .pend   (pend),
    .en     (en)
  );

  ecc_log_capture #(.BLK_W(BLK_W), .SYN_W(SYN_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_evt   (ce_evt),
    .ue_evt   (ue_evt),
    .ce_pend  (ce_st),
    .ue_pend  (ue_st),
    .evt_blk  (evt_addr[ADDR_W-1:BLK_LSB]),
    .evt_syn  (evt_syn),
    .evt_chan (evt_chan),
    .det_blk  (det_blk),
    .det_syn  (det_syn),
    .det_chan (det_chan)
  );

  ecc_log_regif #(.DATA_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_regif (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend),
    .en        (en),
    .det_blk   (det_blk),
    .det_syn   (det_syn),
    .det_chan  (det_chan),
    .clr       (clr),
    .cmd_we    (cmd_we),
    .cmd_d     (cmd_d),
    .reg_rdata (reg_rdata)
  );

  // Level request: any pending kind whose enable is set
  assign sys_err = |(pend & en);
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_evt,
  input logic             ue_evt,
  input logic [SYN_W-1:0] evt_syn,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic             wdata_b0,
  input logic             ce_st,
  input logic             ue_st,
  input logic [BLK_W-1:0] det_blk,
  input logic [SYN_W-1:0] det_syn,
  input logic             sys_err
);
  p_ce_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> ce_st);

  p_ue_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> ue_st);

  p_ue_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !ue_st) |=> (det_syn == $past(evt_syn)));

  p_ce_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && ue_st) |=> ($stable(det_syn) && $stable(det_blk)));

  p_ce_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && ce_st) |=> ($stable(det_syn) && $stable(det_blk)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && wdata_b0 && !ce_evt) |=> !ce_st);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_st && !ue_st) |-> !sys_err);
endmodule

bind ecc_err_log ecc_err_log_chk #(.BLK_W(BLK_W), .SYN_W(SYN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_evt   (ce_evt),
  .ue_evt   (ue_evt),
  .evt_syn  (evt_syn),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .wdata_b0 (reg_wdata[0]),
  .ce_st    (ce_st),
  .ue_st    (ue_st),
  .det_blk  (det_blk),
  .det_syn  (det_syn),
  .sys_err  (sys_err)
);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 1'b0, ue_evt = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic        evt_chan = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_err;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_err(sys_err)
  );

  localparam logic [2:0] O_ST = 3'd0, O_CMD = 3'd1, O_ADR = 3'd2,
                         O_SYN = 3'd3, O_CH = 3'd4;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  // Tasks begin just after a falling edge and end on the next one
  task automatic evt(input logic ce, input logic ue, input logic [31:0] a,
                     input logic [7:0] s, input logic ch);
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = ch;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    rd(O_ST, 32'h0, "R1 status");
    rd(O_CMD, 32'h0, "R1 command");
    rd(O_ADR, 32'h0, "R1 address");
    rd(O_SYN, 32'h0, "R1 syndrome");
    rd(O_CH, 32'h0, "R1 channel");
    chk("R1 sys_err", {31'b0, sys_err}, 32'h0);
  endtask

  task automatic t_ce_first;
    evt(1, 0, 32'h1234_5ABC, 8'h5A, 1);
    rd(O_ST, 32'h0000_0001, "R2 status");
    rd(O_ADR, 32'h1234_5000, "R2/R10 address");
    rd(O_SYN, 32'h0000_005A, "R2 syndrome");
    rd(O_CH, 32'h0000_0001, "R2/R10 channel");
  endtask

  task automatic t_ce_repeat;
    evt(1, 0, 32'hAAAA_A111, 8'h33, 0);
    rd(O_ADR, 32'h1234_5000, "R6 address kept");
    rd(O_SYN, 32'h0000_005A, "R6 syndrome kept");
    rd(O_CH, 32'h0000_0001, "R6 channel kept");
  endtask

  task automatic t_ue_over;
    evt(0, 1, 32'h8000_0FFF, 8'hC3, 0);
    rd(O_ST, 32'h0000_0081, "R4 status");
    rd(O_ADR, 32'h8000_0000, "R4/R10 address");
    rd(O_SYN, 32'h0000_00C3, "R4 syndrome");
    rd(O_CH, 32'h0000_0000, "R4 channel");
  endtask

  task automatic t_ce_under_ue;
    wr(O_ST, 32'h0000_0001);
    rd(O_ST, 32'h0000_0080, "R7 clear bit0 only");
    evt(1, 0, 32'h7777_7000, 8'h11, 1);
    rd(O_ST, 32'h0000_0081, "R5 status");
    rd(O_SYN, 32'h0000_00C3, "R5 syndrome kept");
    rd(O_ADR, 32'h8000_0000, "R5 address kept");
    rd(O_CH, 32'h0000_0000, "R5 channel kept");
  endtask

  task automatic t_ue_repeat;
    evt(0, 1, 32'h1111_1000, 8'h22, 1);
    rd(O_SYN, 32'h0000_00C3, "R12 syndrome kept");
    rd(O_ADR, 32'h8000_0000, "R12 address kept");
  endtask

  task automatic t_w1c;
    wr(O_ST, 32'hFFFF_FF7E);
    rd(O_ST, 32'h0000_0081, "R7 zero bits no effect");
    wr(O_ST, 32'h0000_0080);
    rd(O_ST, 32'h0000_0001, "R7 clear bit7");
    wr(O_ST, 32'h0000_0001);
    rd(O_ST, 32'h0000_0000, "R7 clear bit0");
  endtask

  task automatic t_same_cycle;
    reg_addr = O_ST; reg_wdata = 32'h0000_0081; reg_wr = 1'b1;
    evt(1, 0, 32'h0000_3000, 8'h44, 0);
    reg_wr = 1'b0;
    rd(O_ST, 32'h0000_0001, "R8 CE beats clear");
    reg_addr = O_ST; reg_wdata = 32'h0000_0081; reg_wr = 1'b1;
    evt(0, 1, 32'h0000_5000, 8'h55, 0);
    reg_wr = 1'b0;
    rd(O_ST, 32'h0000_0080, "R8 UE beats clear");
    wr(O_ST, 32'h0000_0081);
    rd(O_ST, 32'h0000_0000, "R8 cleared after");
  endtask

  task automatic t_both;
    evt(1, 1, 32'h0ABC_D123, 8'h99, 1);
    rd(O_ST, 32'h0000_0081, "R11 status");
    rd(O_ADR, 32'h0ABC_D000, "R11 address");
    rd(O_SYN, 32'h0000_0099, "R11 syndrome");
    rd(O_CH, 32'h0000_0001, "R11 channel");
    wr(O_ST, 32'h0000_0081);
  endtask

  task automatic t_sys_err;
    wr(O_CMD, 32'hFFFF_FFFF);
    rd(O_CMD, 32'h0000_0180, "R9 command readback");
    chk("R9 idle no request", {31'b0, sys_err}, 32'h0);
    evt(1, 0, 32'h0, 8'h01, 0);
    chk("R9 CE enabled", {31'b0, sys_err}, 32'h1);
    wr(O_CMD, 32'h0000_0100);
    chk("R9 CE masked", {31'b0, sys_err}, 32'h0);
    evt(0, 1, 32'h0, 8'h02, 0);
    chk("R9 UE enabled", {31'b0, sys_err}, 32'h1);
    wr(O_CMD, 32'h0000_0080);
    chk("R9 CE enabled UE masked", {31'b0, sys_err}, 32'h1);
    wr(O_ST, 32'h0000_0001);
    chk("R9 only UE pending masked", {31'b0, sys_err}, 32'h0);
    wr(O_ST, 32'h0000_0080);
    chk("R9 nothing pending", {31'b0, sys_err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ce_first();
    t_ce_repeat();
    t_ue_over();
    t_ce_under_ue();
    t_ue_repeat();
    t_w1c();
    t_same_cycle();
    t_both();
    t_sys_err();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule